// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block sends a stereo pair of 20-bit two's-complement samples, most significant bit first, over a three-wire serial audio link. The link has a bit clock, a word clock and a data line, plus a frame-sync line. Everything runs on one master clock. In master mode the block divides that clock to produce the bit clock, the word clock and a frame-sync at twice the word rate. In slave mode it watches bit, word and frame-sync clocks driven from outside, samples them on the master clock and acts on each falling bit-clock edge it sees.

Two mode inputs set the direction and the framing. `mode_m` picks master or slave. `mode_i2s` sets the word-clock polarity: with `mode_i2s` low, a high word clock marks the left slot, and with it high, a low word clock marks the left slot. In slave mode `mode_i2s` also picks between I2S timing and MSB-justified timing. In MSB-justified slave timing the external frame-sync gates each data bit. A fresh left/right pair is taken from the parallel inputs when each left slot begins. A power-down input silences the outputs and restarts the timing.

Top module: `stereo_serial_tx`

## Requirements
- R1: In master mode `sclk_o` is the master clock divided by 4 when `clk_sel`=0 and by 6 when `clk_sel`=1. It has 50% duty and is low for the first half of each period, counting from reset release.
- R2: In master mode a frame is 64 bit-clock periods: a 32-period left slot followed by a 32-period right slot. `lrck_o` equals `!mode_i2s` during the left slot and `mode_i2s` during the right slot, and changes only on a falling `sclk_o`.
- R3: In master mode `fsync_o` is high for the first 16 bit periods of each 32-period slot and low for the other 16, giving a rate of twice the frame rate.
- R4: `sdata_o` changes only on a falling bit-clock edge. In master mode it changes on the same master-clock edge that takes `sclk_o` low. In slave mode it changes on the first master-clock edge at which `sclk_i` is seen low after being high.
- R5: In master mode and in slave I2S mode (`mode_i2s`=1), `sdata_o` is low in bit period 0 of a slot and carries the word MSB in period 1. In slave MSB-justified mode the MSB goes out at the first gated bit of the slot.
- R6: Each word goes out MSB first, unchanged (two's complement). `sdata_o` is low for the rest of the slot once all 20 bits have gone out.
- R7: `left_i`/`right_i` are latched when a left slot begins, so changes during a frame appear only in the next frame. After reset, the master mode's first frame sends zero words.
- R8: In slave MSB-justified mode (`mode_m`=0, `mode_i2s`=0), a bit is sent only at falling `sclk_i` edges where `fsync_i` is high. At other edges `sdata_o` is low and the bit position holds. The position restarts at each slot.
- R9: In slave I2S mode `fsync_i` has no effect on `sdata_o`.
- R10: In slave mode a slot begins at a falling `sclk_i` edge where `lrck_i` differs from its level at the previous falling edge. The slot is left when `lrck_i` equals `!mode_i2s`. `sclk_o`, `lrck_o` and `fsync_o` are driven low.
- R11: While `pdn_n` is low, `sclk_o`, `fsync_o` and `sdata_o` are low and master `lrck_o` rests at the left level. When `pdn_n` rises, timing restarts as after reset.
- R12: While `rst_n` is low in master mode, `lrck_o` is at the left level (`!mode_i2s`) and `sclk_o`, `fsync_o` and `sdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_n | input | 1 | Power-down, active low |
| clk_sel | input | 1 | 0: master clock is 256x word rate, 1: 384x |
| mode_m | input | 1 | 1: master, 0: slave |
| mode_i2s | input | 1 | Word-clock polarity / slave framing select |
| left_i | input | 20 | Left sample word |
| right_i | input | 20 | Right sample word |
| sclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External word clock (slave) |
| fsync_i | input | 1 | External frame-sync (slave MSB-justified) |
| sclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated word clock (master) |
| fsync_o | output | 1 | Generated frame-sync (master) |
| sdata_o | output | 1 | Serial data |

## Verification
In master mode every output is a fixed function of how many master-clock edges have passed since reset or power-down release. `sclk_o`, `lrck_o`, `fsync_o` and `sdata_o` all move on the edge that ends a divider period, so each is checked half a master-clock period after every edge against a count the bench keeps itself. In slave mode `sdata_o` updates on the first master-clock edge after `sclk_i` is driven low. The bench therefore holds each external bit-clock level for three master cycles and reads `sdata_o` just before raising `sclk_i`, well after the update. The power-down and reset gating act within the same cycle, so those outputs are read at the first falling master-clock edge after the control changes.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int WORD_W   = 20,
  parameter int SLOT_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              clk_sel,
  input  logic              mode_m,
  input  logic              mode_i2s,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              fsync_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              fsync_o,
  output logic              sdata_o
);
  localparam int POS_W = $clog2(SLOT_LEN);
  localparam int IDX_W = $clog2(WORD_W + 1);

  logic [2:0]        div_cnt;
  logic [POS_W-1:0]  pos;
  logic              side;
  logic [IDX_W-1:0]  didx;
  logic [WORD_W-1:0] sh_l, sh_r;
  logic              sdata_r, sclk_d, lrck_last;

  logic [2:0]        div_lim, div_half;
  logic              left_lvl, adv, s_start, start, latch, nside, shift_en, emit;
  logic [POS_W:0]    m_nxt;
  logic [POS_W-1:0]  npos;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word, shifted;

  assign div_lim  = clk_sel ? 3'd5 : 3'd3;
  assign div_half = clk_sel ? 3'd3 : 3'd2;
  assign left_lvl = ~mode_i2s;
  assign adv      = mode_m ? (div_cnt >= div_lim) : (sclk_d & ~sclk_i);
  assign s_start  = ~mode_m & (lrck_i != lrck_last);
  assign m_nxt    = {side, pos} + 1'b1;

  always_comb begin
    if (mode_m) begin
      npos  = m_nxt[POS_W-1:0];
      nside = m_nxt[POS_W];
      start = (m_nxt[POS_W-1:0] == '0);
    end else begin
      npos  = s_start ? '0 : ((pos == POS_W'(SLOT_LEN - 1)) ? pos : pos + 1'b1);
      nside = s_start ? (lrck_i != left_lvl) : side;
      start = s_start;
    end
  end

  assign latch    = start & ~nside;
  assign shift_en = (~mode_m & ~mode_i2s) ? fsync_i : (npos != '0);
  assign idx      = start ? '0 : didx;
  assign word     = nside ? sh_r : (latch ? left_i : sh_l);
  assign emit     = shift_en & (idx < IDX_W'(WORD_W));
  assign shifted  = word << idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      pos       <= '0;
      side      <= 1'b0;
      didx      <= IDX_W'(WORD_W);
      sdata_r   <= 1'b0;
      sclk_d    <= 1'b0;
      lrck_last <= 1'b0;
      sh_l      <= '0;
      sh_r      <= '0;
    end else if (!pdn_n) begin
      div_cnt   <= '0;
      pos       <= '0;
      side      <= 1'b0;
      didx      <= IDX_W'(WORD_W);
      sdata_r   <= 1'b0;
      sclk_d    <= 1'b0;
      lrck_last <= 1'b0;
    end else begin
      sclk_d  <= sclk_i;
      div_cnt <= (mode_m && !adv) ? div_cnt + 3'd1 : 3'd0;
      if (adv) begin
        pos       <= npos;
        side      <= nside;
        didx      <= emit ? IDX_W'(idx + 1'b1) : idx;
        sdata_r   <= emit & shifted[WORD_W-1];
        lrck_last <= lrck_i;
        if (latch) begin
          sh_l <= left_i;
          sh_r <= right_i;
        end
      end
    end
  end

  assign sclk_o  = mode_m & pdn_n & rst_n & (div_cnt >= div_half);
  assign lrck_o  = mode_m & (side ? ~left_lvl : left_lvl);
  assign fsync_o = mode_m & pdn_n & rst_n & ~pos[POS_W-1];
  assign sdata_o = sdata_r & pdn_n;
endmodule

module stereo_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pdn_n,
  input logic mode_m,
  input logic mode_i2s,
  input logic sclk_o,
  input logic lrck_o,
  input logic fsync_o,
  input logic sdata_o
);
  // R11
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |-> (!sclk_o && !fsync_o && !sdata_o));

  // R12
  rst_lrck_chk: assert property (@(posedge clk)
    (!rst_n && mode_m) |-> (lrck_o == !mode_i2s && !sclk_o && !sdata_o));

  // R4
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_m && $past(mode_m) && pdn_n && $past(pdn_n) && $past(rst_n) && !$stable(sdata_o))
    |-> $fell(sclk_o));

  // R2
  lrck_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_m && $past(mode_m) && pdn_n && $past(pdn_n) && $past(rst_n) && !$stable(lrck_o))
    |-> $fell(sclk_o));

  // R3
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_m && $past(mode_m) && pdn_n && $past(pdn_n) && $past(rst_n) && !$stable(fsync_o))
    |-> $fell(sclk_o));

  // R5
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_m && $past(mode_m) && pdn_n && $past(pdn_n) && $past(rst_n) && !$stable(lrck_o))
    |-> !sdata_o);
endmodule

bind stereo_serial_tx stereo_serial_tx_chk u_chk (.*);

// File: tb/tb_stereo_serial_tx.sv
`timescale 1ns/1ps
module tb_stereo_serial_tx;
  localparam int W = 20;

  logic clk = 0, rst_n = 0, pdn_n = 1, clk_sel = 0, mode_m = 1, mode_i2s = 0;
  logic [W-1:0] left_i = '0, right_i = '0;
  logic sclk_i = 1, lrck_i = 0, fsync_i = 0;
  logic sclk_o, lrck_o, fsync_o, sdata_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stereo_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .clk_sel(clk_sel), .mode_m(mode_m),
    .mode_i2s(mode_i2s), .left_i(left_i), .right_i(right_i), .sclk_i(sclk_i),
    .lrck_i(lrck_i), .fsync_i(fsync_i), .sclk_o(sclk_o), .lrck_o(lrck_o),
    .fsync_o(fsync_o), .sdata_o(sdata_o)
  );

  // {clk_sel, mode_i2s, left1, right1, left2, right2}
  localparam logic [81:0] VEC [4] = '{
    {1'b0, 1'b0, 20'hA5C3F, 20'h80001, 20'h7FFFE, 20'h00001},
    {1'b1, 1'b0, 20'h12345, 20'hFEDCB, 20'h55555, 20'hAAAAA},
    {1'b0, 1'b1, 20'hFFFFF, 20'h00000, 20'h80000, 20'h7FFFF},
    {1'b1, 1'b1, 20'h0F0F0, 20'hC0003, 20'h3C3C3, 20'h96969}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit m, input bit sel, input bit i2s, input bit lv);
    @(negedge clk);
    rst_n = 0; pdn_n = 1; mode_m = m; clk_sel = sel; mode_i2s = i2s;
    sclk_i = 1; lrck_i = lv; fsync_i = 0; left_i = '0; right_i = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_master(input logic [81:0] v);
    bit sel, i2s, sd, prev;
    logic [W-1:0] l1, r1, l2, r2, word;
    int dv, k, ph, b, p, fr;
    bit sd_side;
    string tag;
    sel = v[81]; i2s = v[80];
    l1 = v[79:60]; r1 = v[59:40]; l2 = v[39:20]; r2 = v[19:0];
    dv = sel ? 6 : 4;
    do_reset(1'b1, sel, i2s, 1'b0);
    left_i = l1; right_i = r1;
    chk(lrck_o == !i2s, "R12 reset lrck", lrck_o, !i2s);
    chk(!sclk_o && !fsync_o && !sdata_o, "R12 reset quiet", {sclk_o, fsync_o, sdata_o}, 0);
    rst_n = 1;
    prev = 0;
    for (int n = 1; n <= 192 * dv; n++) begin
      @(negedge clk);
      k = n / dv; ph = n % dv; b = k % 64; sd_side = (b >= 32); p = b % 32; fr = k / 64;
      word = (fr == 0) ? '0 : (fr == 1) ? (sd_side ? r1 : l1) : (sd_side ? r2 : l2);
      sd = (p >= 1 && p <= W) ? word[W - p] : 1'b0;
      chk(sclk_o == (ph >= dv / 2), "R1 sclk", sclk_o, ph >= dv / 2);
      chk(lrck_o == (sd_side ? i2s : !i2s), "R2 lrck", lrck_o, sd_side ? i2s : !i2s);
      chk(fsync_o == (p < 16), "R3 fsync", fsync_o, p < 16);
      tag = (fr == 0) ? "R7 first frame zero" : (p == 0) ? "R5 slot delay" :
            (p > W) ? "R6 tail low" : (fr == 2) ? "R7 latched pair" : "R6 msb first";
      chk(sdata_o == sd, tag, sdata_o, sd);
      chk(!(sdata_o != prev && ph != 0), "R4 data edge", sdata_o, prev);
      prev = sdata_o;
      if (n == 104 * dv) begin left_i = l2; right_i = r2; end
    end
  endtask

  task automatic run_slave(input bit i2s);
    logic [W-1:0] l1, r1, l2, r2, word;
    bit lv, fs, rside, ex;
    int idx, fr;
    l1 = 20'h9B3D5; r1 = 20'h4C2E1; l2 = 20'h1F80E; r2 = 20'hE07F1;
    do_reset(1'b0, 1'b0, i2s, i2s);
    left_i = l1; right_i = r1;
    rst_n = 1;
    for (int s = 0; s < 5; s++) begin
      rside = (s % 2 == 0);
      lv = rside ? i2s : !i2s;
      fr = (s + 1) / 2;
      idx = 0;
      for (int p = 0; p < 32; p++) begin
        fs = !(p < 2 || (p >= 11 && p < 14));
        @(negedge clk);
        sclk_i = 0; lrck_i = lv; fsync_i = fs;
        repeat (3) @(negedge clk);
        word = (fr == 0) ? '0 : (fr == 1) ? (rside ? r1 : l1) : (rside ? r2 : l2);
        if (i2s) begin
          ex = (p >= 1 && p <= W) ? word[W - p] : 1'b0;
          chk(sdata_o == ex, "R9 i2s slave fsync ignored", sdata_o, ex);
        end else begin
          if (fs && idx < W) begin ex = word[W - 1 - idx]; idx++; end
          else ex = 1'b0;
          chk(sdata_o == ex, fs ? "R8 gated bit" : "R8 gated low", sdata_o, ex);
        end
        if (s == 1 && p == 0)
          chk(!sclk_o && !lrck_o && !fsync_o, "R10 slave outputs low",
              {sclk_o, lrck_o, fsync_o}, 0);
        if (s == 1 && p == 8) begin left_i = l2; right_i = r2; end // R7
        sclk_i = 1;
        repeat (3) @(negedge clk);
      end
    end
  endtask

  task automatic run_pd();
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    rst_n = 1;
    repeat (300) @(negedge clk);
    pdn_n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!sclk_o && !fsync_o && !sdata_o, "R11 pd quiet", {sclk_o, fsync_o, sdata_o}, 0);
      chk(lrck_o == 1'b1, "R11 pd lrck left", lrck_o, 1);
    end
    pdn_n = 1;
    for (int n = 1; n <= 32; n++) begin
      @(negedge clk);
      chk(sclk_o == ((n % 4) >= 2), "R11 restart sclk", sclk_o, (n % 4) >= 2);
      chk(lrck_o == 1'b1, "R11 restart lrck", lrck_o, 1);
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) run_master(VEC[c]);
    run_slave(1'b0);
    run_slave(1'b1);
    run_pd();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule